// File: doc/BRIEF.md
# UART Receive Character Queue with Per-Byte Error Tags

This block is the receive-side buffer of a 16550-class serial channel. A receive shift register delivers each finished character as one strobe. The strobe carries the data byte and three error flags: parity error, framing error and break. The block stores the byte and its flags together as one entry, so each flag stays with the byte it describes. The oldest unread entry is shown to the host as a read-only holding register.

The host reads the holding register with a pop strobe. The line-status error bits always describe the byte currently at the head of the queue. They change to the next byte's flags in the cycle right after a pop. A data-ready bit shows that something is held, and an overrun bit records a character that was lost. A receive interrupt is raised on every character in single-register mode, or at a selectable fill level in queue mode.

Top module: `uart_rxq`

## Requirements
- R1: After reset these outputs are all 0: `lsr_dr`, `lsr_oe`, `lsr_pe`, `lsr_fe`, `lsr_bi`, `rx_irq` and `hold_data`.
- R2: With `fifo_en`=1, characters leave in arrival order. `hold_data` shows the oldest unread byte, and after a pop it shows the next byte in the following cycle. `lsr_dr` is 1 exactly when at least one entry is held.
- R3: Each entry keeps its own tags. `lsr_pe` (status bit 2) is the head's parity flag, `lsr_fe` (bit 3) its framing flag and `lsr_bi` (bit 4) its break flag. They take the new head's values in the cycle after a pop, and all three read 0 while the queue is empty.
- R4: With `fifo_en`=1 the queue holds 16 entries. A character arriving while 16 are held, with no pop in the same cycle, is discarded and the stored bytes are kept. It also sets `lsr_oe`, which stays 1 until a flush.
- R5: With `fifo_en`=0 the block holds a single character. A second arrival while one is held, with no pop in the same cycle, is discarded and sets `lsr_oe`.
- R6: With `fifo_en`=1 and `int_en`=1, `rx_irq` is 1 exactly when the fill count is at or above the trigger level. `trig_sel` selects the level: 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 14. `rx_irq` drops as soon as the count falls below the level.
- R7: With `fifo_en`=0 and `int_en`=1, `rx_irq` is 1 while a character is held and 0 when none is held.
- R8: With `int_en`=0, `rx_irq` is 0 whatever the queue holds.
- R9: A `rx_flush` pulse empties the queue and clears `lsr_oe` and the error bits. A push or pop in the same cycle is ignored. The next character accepted after a flush becomes the head.
- R10: A pop while the queue is empty has no effect. Characters pushed afterwards come out in order, and none is lost.
- R11: A push and a pop in the same cycle on a full queue are both accepted. No overrun is flagged, and the new byte goes to the tail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_en | input | 1 | 1: 16-entry queue mode, 0: single holding register |
| trig_sel | input | 2 | Interrupt fill-level select |
| int_en | input | 1 | Receive interrupt enable |
| rx_flush | input | 1 | One-cycle receive reset strobe |
| wr_valid | input | 1 | Completed character strobe from the shift register |
| wr_data | input | 8 | Received byte |
| wr_perr | input | 1 | Parity error flag of the byte |
| wr_ferr | input | 1 | Framing error flag of the byte |
| wr_brk | input | 1 | Break flag of the byte |
| rd_pop | input | 1 | Host read of the holding register |
| hold_data | output | 8 | Oldest unread byte, 0 when empty |
| lsr_dr | output | 1 | Data ready |
| lsr_oe | output | 1 | Overrun, sticky |
| lsr_pe | output | 1 | Head parity error |
| lsr_fe | output | 1 | Head framing error |
| lsr_bi | output | 1 | Head break |
| rx_irq | output | 1 | Receive data interrupt |

## Verification
A read or write pointer that slips shows up at the ports one cycle after the faulty push or pop. `hold_data` then returns a byte out of order, or tags that belong to a neighbouring byte. A fill count that drifts from the true occupancy shows in several ways: `lsr_dr` stays high on an empty queue, `rx_irq` crosses its level one character early or late, or `lsr_oe` rises before 16 entries are held. Each of these appears in the cycle after the stimulus that caused it. The directed tests therefore sample every output after each single push or pop.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;

   // error flags carried beside every stored byte
   typedef struct packed {
      logic brk;
      logic ferr;
      logic perr;
   } rxq_tags_t;

   localparam int unsigned TAG_W = $bits(rxq_tags_t);

   typedef enum logic [1:0] {
      TRIG_SEL_A = 2'b00,
      TRIG_SEL_B = 2'b01,
      TRIG_SEL_C = 2'b10,
      TRIG_SEL_D = 2'b11
   } rxq_trig_e;

endpackage

// File: rtl/uart_rxq_store.sv
module uart_rxq_store #(
   parameter int unsigned ENT_W = 11,
   parameter int unsigned DEPTH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             push,
   input  logic             pop,
   input  logic [ENT_W-1:0] wdata,
   output logic [ENT_W-1:0] rdata
);
   localparam int unsigned AW = $clog2(DEPTH);

   logic [AW-1:0]    wr_ptr;
   logic [AW-1:0]    rd_ptr;
   logic [ENT_W-1:0] slot [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
      end else if (clr) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
      end else begin
         if (push) wr_ptr <= wr_ptr + 1'b1;
         if (pop)  rd_ptr <= rd_ptr + 1'b1;
      end
   end

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            slot[g] <= '0;
         else if (push && (wr_ptr == AW'(g)))
            slot[g] <= wdata;
      end
   end

   assign rdata = slot[rd_ptr];

endmodule

// File: rtl/uart_rxq_ctrl.sv
module uart_rxq_ctrl #(
   parameter int unsigned DEPTH = 16,
   localparam int unsigned CNT_W = $clog2(DEPTH) + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             fifo_en,
   input  logic             wr_valid,
   input  logic             rd_req,
   output logic             push,
   output logic             pop,
   output logic [CNT_W-1:0] count,
   output logic             overrun
);
   logic [CNT_W-1:0] cap;
   logic             full;
   logic             lost;

   assign cap  = fifo_en ? CNT_W'(DEPTH) : CNT_W'(1);
   assign full = (count >= cap);
   assign pop  = rd_req && (count != '0) && !clr;
   assign push = wr_valid && !clr && (!full || pop);
   assign lost = wr_valid && !clr && full && !pop;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count   <= '0;
         overrun <= 1'b0;
      end else if (clr) begin
         count   <= '0;
         overrun <= 1'b0;
      end else begin
         case ({push, pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
         if (lost) overrun <= 1'b1;
      end
   end

endmodule

// File: rtl/uart_rxq_irq.sv
module uart_rxq_irq
   import uart_rxq_pkg::*;
#(
   parameter int unsigned CNT_W  = 5,
   parameter int unsigned TRIG_A = 1,
   parameter int unsigned TRIG_B = 4,
   parameter int unsigned TRIG_C = 8,
   parameter int unsigned TRIG_D = 14
) (
   input  logic [CNT_W-1:0] count,
   input  logic             fifo_en,
   input  logic [1:0]       trig_sel,
   input  logic             int_en,
   output logic             irq
);
   logic [CNT_W-1:0] level;
   logic             hit;

   always_comb begin
      unique case (rxq_trig_e'(trig_sel))
         TRIG_SEL_A: level = CNT_W'(TRIG_A);
         TRIG_SEL_B: level = CNT_W'(TRIG_B);
         TRIG_SEL_C: level = CNT_W'(TRIG_C);
         default:    level = CNT_W'(TRIG_D);
      endcase
   end

   assign hit = fifo_en ? (count >= level) : (count != '0);
   assign irq = int_en && hit;

endmodule

// File: rtl/uart_rxq.sv
module uart_rxq
   import uart_rxq_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned DEPTH  = 16,
   parameter int unsigned TRIG_A = 1,
   parameter int unsigned TRIG_B = 4,
   parameter int unsigned TRIG_C = 8,
   parameter int unsigned TRIG_D = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fifo_en,
   input  logic [1:0]        trig_sel,
   input  logic              int_en,
   input  logic              rx_flush,
   input  logic              wr_valid,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              wr_perr,
   input  logic              wr_ferr,
   input  logic              wr_brk,
   input  logic              rd_pop,
   output logic [DATA_W-1:0] hold_data,
   output logic              lsr_dr,
   output logic              lsr_oe,
   output logic              lsr_pe,
   output logic              lsr_fe,
   output logic              lsr_bi,
   output logic              rx_irq
);
   localparam int unsigned ENT_W = DATA_W + TAG_W;
   localparam int unsigned CNT_W = $clog2(DEPTH) + 1;

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("uart_rxq: DEPTH must be a power of two, at least 2");
   end
   if (TRIG_A < 1 || TRIG_D > DEPTH || TRIG_A > TRIG_B ||
       TRIG_B > TRIG_C || TRIG_C > TRIG_D) begin : g_bad_trig
      $error("uart_rxq: trigger levels must rise within 1..DEPTH");
   end

   logic             push, pop;
   logic [CNT_W-1:0] occ_cnt;
   logic [ENT_W-1:0] wr_ent, head_ent;
   rxq_tags_t        wr_tags, head_tags;
   logic             nonempty;

   assign wr_tags = '{brk: wr_brk, ferr: wr_ferr, perr: wr_perr};
   assign wr_ent  = {wr_tags, wr_data};

   uart_rxq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (rx_flush),
      .fifo_en  (fifo_en),
      .wr_valid (wr_valid),
      .rd_req   (rd_pop),
      .push     (push),
      .pop      (pop),
      .count    (occ_cnt),
      .overrun  (lsr_oe)
   );

   uart_rxq_store #(.ENT_W(ENT_W), .DEPTH(DEPTH)) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (rx_flush),
      .push  (push),
      .pop   (pop),
      .wdata (wr_ent),
      .rdata (head_ent)
   );

   uart_rxq_irq #(
      .CNT_W (CNT_W),
      .TRIG_A(TRIG_A), .TRIG_B(TRIG_B), .TRIG_C(TRIG_C), .TRIG_D(TRIG_D)
   ) u_irq (
      .count    (occ_cnt),
      .fifo_en  (fifo_en),
      .trig_sel (trig_sel),
      .int_en   (int_en),
      .irq      (rx_irq)
   );

   assign nonempty  = (occ_cnt != '0);
   assign head_tags = rxq_tags_t'(head_ent[ENT_W-1:DATA_W]);

   assign lsr_dr    = nonempty;
   assign hold_data = nonempty ? head_ent[DATA_W-1:0] : '0;
   assign lsr_pe    = nonempty && head_tags.perr;
   assign lsr_fe    = nonempty && head_tags.ferr;
   assign lsr_bi    = nonempty && head_tags.brk;

endmodule

// File: rtl/uart_rxq_chk.sv
module uart_rxq_chk #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned DEPTH  = 16,
   localparam int unsigned CNT_W = $clog2(DEPTH) + 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              fifo_en,
   input logic              int_en,
   input logic              rx_flush,
   input logic              wr_valid,
   input logic              rd_pop,
   input logic [DATA_W-1:0] hold_data,
   input logic              lsr_dr,
   input logic              lsr_oe,
   input logic              lsr_pe,
   input logic              lsr_fe,
   input logic              lsr_bi,
   input logic              rx_irq,
   input logic [CNT_W-1:0]  occ_cnt
);
   // R2: head byte holds still while nothing is popped or flushed
   a_r2_head_stable: assert property (@(posedge clk) disable iff (!rst_n)
      lsr_dr && !rd_pop && !rx_flush |=> $stable(hold_data));

   // R3: no error tag is reported on an empty queue
   a_r3_tags_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !lsr_dr |-> !(lsr_pe || lsr_fe || lsr_bi));

   // R4: occupancy never goes past the store depth
   a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      occ_cnt <= CNT_W'(DEPTH));

   // R4: overrun stays set until a flush
   a_r4_oe_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      lsr_oe && !rx_flush |=> lsr_oe);

   // R5: a second character in single-register mode is an overrun
   a_r5_single_full: assert property (@(posedge clk) disable iff (!rst_n)
      !fifo_en && lsr_dr && wr_valid && !rd_pop && !rx_flush |=> lsr_oe);

   // R7: single-register interrupt follows data ready
   a_r7_single_irq: assert property (@(posedge clk) disable iff (!rst_n)
      int_en && !fifo_en |-> (rx_irq == lsr_dr));

   // R8: interrupt masked by enable
   a_r8_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
      !int_en |-> !rx_irq);

   // R9: flush leaves an empty, clean status
   a_r9_flush_clean: assert property (@(posedge clk) disable iff (!rst_n)
      rx_flush |=> !lsr_dr && !lsr_oe && !lsr_pe && !lsr_fe && !lsr_bi);

   // R10: a pop on an empty queue changes nothing
   a_r10_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
      !lsr_dr && rd_pop && !wr_valid |=> !lsr_dr);
endmodule

bind uart_rxq uart_rxq_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .fifo_en  (fifo_en),
   .int_en   (int_en),
   .rx_flush (rx_flush),
   .wr_valid (wr_valid),
   .rd_pop   (rd_pop),
   .hold_data(hold_data),
   .lsr_dr   (lsr_dr),
   .lsr_oe   (lsr_oe),
   .lsr_pe   (lsr_pe),
   .lsr_fe   (lsr_fe),
   .lsr_bi   (lsr_bi),
   .rx_irq   (rx_irq),
   .occ_cnt  (occ_cnt)
);

// File: tb/test_uart_rxq.sv
module test_uart_rxq;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       fifo_en = 1'b1;
   logic [1:0] trig_sel = 2'b00;
   logic       int_en = 1'b0;
   logic       rx_flush = 1'b0;
   logic       wr_valid = 1'b0;
   logic [7:0] wr_data = '0;
   logic       wr_perr = 1'b0, wr_ferr = 1'b0, wr_brk = 1'b0;
   logic       rd_pop = 1'b0;
   logic [7:0] hold_data;
   logic       lsr_dr, lsr_oe, lsr_pe, lsr_fe, lsr_bi, rx_irq;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;
   bit done = 0;

   always #10 clk = ~clk;   // 50 MHz

   uart_rxq i_uart_rxq (
      .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .trig_sel(trig_sel),
      .int_en(int_en), .rx_flush(rx_flush), .wr_valid(wr_valid),
      .wr_data(wr_data), .wr_perr(wr_perr), .wr_ferr(wr_ferr), .wr_brk(wr_brk),
      .rd_pop(rd_pop), .hold_data(hold_data), .lsr_dr(lsr_dr), .lsr_oe(lsr_oe),
      .lsr_pe(lsr_pe), .lsr_fe(lsr_fe), .lsr_bi(lsr_bi), .rx_irq(rx_irq)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000 && !done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual %0d expected below 100000", cyc);
         summary();
      end
   end

   // every step starts and ends on a falling edge
   task automatic push(input logic [7:0] d, input logic [2:0] tg);
      wr_valid = 1'b1; wr_data = d; {wr_brk, wr_ferr, wr_perr} = tg;
      @(negedge clk);
      wr_valid = 1'b0; {wr_brk, wr_ferr, wr_perr} = 3'b000;
   endtask

   task automatic pop();
      rd_pop = 1'b1;
      @(negedge clk);
      rd_pop = 1'b0;
   endtask

   task automatic flush();
      rx_flush = 1'b1;
      @(negedge clk);
      rx_flush = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 dr", lsr_dr, 0);
      chk("R1 oe", lsr_oe, 0);
      chk("R1 tags", {lsr_bi, lsr_fe, lsr_pe}, 0);
      chk("R1 irq", rx_irq, 0);
      chk("R1 hold", hold_data, 0);
   endtask

   task automatic t_order_tags();
      fifo_en = 1'b1; flush();
      for (int i = 0; i < 6; i++) push(8'hA0 + 8'(i), 3'(i + 1));
      for (int i = 0; i < 6; i++) begin
         chk("R2 head", hold_data, 8'hA0 + i);
         chk("R2 dr", lsr_dr, 1);
         chk("R3 tags", {lsr_bi, lsr_fe, lsr_pe}, (i + 1) & 7);
         pop();
      end
      chk("R2 dr empty", lsr_dr, 0);
      chk("R3 tags empty", {lsr_bi, lsr_fe, lsr_pe}, 0);
   endtask

   task automatic t_overflow();
      fifo_en = 1'b1; flush();
      for (int i = 0; i < 16; i++) push(8'(i + 1), 3'b000);
      chk("R4 no oe at 16", lsr_oe, 0);
      push(8'hEE, 3'b111);
      chk("R4 oe set", lsr_oe, 1);
      for (int i = 0; i < 16; i++) begin
         chk("R4 kept", hold_data, i + 1);
         pop();
      end
      chk("R4 extra dropped", lsr_dr, 0);
      chk("R4 oe sticky", lsr_oe, 1);
      flush();
      chk("R9 oe cleared", lsr_oe, 0);
   endtask

   task automatic t_single();
      fifo_en = 1'b0; int_en = 1'b1; flush();
      chk("R7 irq idle", rx_irq, 0);
      push(8'h3C, 3'b010);
      chk("R7 irq held", rx_irq, 1);
      chk("R5 head", hold_data, 8'h3C);
      push(8'h55, 3'b000);
      chk("R5 oe", lsr_oe, 1);
      chk("R5 head kept", hold_data, 8'h3C);
      chk("R3 tag kept", {lsr_bi, lsr_fe, lsr_pe}, 2);
      pop();
      chk("R5 empty", lsr_dr, 0);
      chk("R7 irq cleared", rx_irq, 0);
      int_en = 1'b0; fifo_en = 1'b1; flush();
   endtask

   task automatic t_trigger();
      int lvl [4] = '{1, 4, 8, 14};
      fifo_en = 1'b1; int_en = 1'b1;
      for (int s = 0; s < 4; s++) begin
         trig_sel = 2'(s); flush();
         for (int k = 1; k < lvl[s]; k++) push(8'(k), 3'b000);
         chk("R6 below level", rx_irq, 0);
         push(8'hF0, 3'b000);
         chk("R6 at level", rx_irq, 1);
         int_en = 1'b0; #1;
         chk("R8 masked", rx_irq, 0);
         int_en = 1'b1; #1;
         pop();
         chk("R6 below after pop", rx_irq, 0);
      end
      int_en = 1'b0; trig_sel = 2'b00; flush();
   endtask

   task automatic t_flush();
      fifo_en = 1'b1;
      push(8'h11, 3'b001); push(8'h22, 3'b100);
      wr_valid = 1'b1; wr_data = 8'h99; rx_flush = 1'b1;
      @(negedge clk);
      wr_valid = 1'b0; rx_flush = 1'b0;
      chk("R9 empty", lsr_dr, 0);
      chk("R9 tags", {lsr_bi, lsr_fe, lsr_pe}, 0);
      push(8'h77, 3'b100);
      chk("R9 new head", hold_data, 8'h77);
      chk("R9 new tags", {lsr_bi, lsr_fe, lsr_pe}, 4);
      flush();
   endtask

   task automatic t_empty_pop();
      fifo_en = 1'b1; flush();
      pop(); pop();
      chk("R10 still empty", lsr_dr, 0);
      push(8'h5A, 3'b000); push(8'h5B, 3'b000);
      chk("R10 head", hold_data, 8'h5A);
      pop();
      chk("R10 second", hold_data, 8'h5B);
      pop();
      chk("R10 drained", lsr_dr, 0);
   endtask

   task automatic t_simul();
      fifo_en = 1'b1; flush();
      for (int i = 0; i < 16; i++) push(8'h40 + 8'(i), 3'b000);
      wr_valid = 1'b1; wr_data = 8'hC5; rd_pop = 1'b1;
      @(negedge clk);
      wr_valid = 1'b0; rd_pop = 1'b0;
      chk("R11 no oe", lsr_oe, 0);
      for (int i = 1; i < 16; i++) begin
         chk("R11 order", hold_data, 8'h40 + i);
         pop();
      end
      chk("R11 tail", hold_data, 8'hC5);
      pop();
      chk("R11 drained", lsr_dr, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_order_tags();
      t_overflow();
      t_single();
      t_trigger();
      t_flush();
      t_empty_pop();
      t_simul();
      done = 1;
      summary();
   end
endmodule